// File: doc/BRIEF.md
# Chained Token Readout Controller

This block is the per-chip readout controller for a front-end chip that shares one data bus with several identical chips on a board. During acquisition the chip records events into a local store. Once conversion is finished the controller waits for a token. The chips form a chain, and the token lets each chip drive the shared bus in turn. When this chip receives the token it sends a header word with its event count, then one word per stored event. It then sends a one-cycle token pulse to the next chip and stays idle until the next acquisition cycle begins.

Static configuration inputs control three things. They mark the chip as the head of the chain, so that the token comes from an external start strobe. They select the token from the chip two positions upstream instead of the adjacent one, so that one dead neighbour can be skipped. They connect or disconnect each of the two redundant data lanes. The controller also produces a readout clock enable that is high only while the chip is transmitting.

Top module: `chain_readout_ctrl`

## Requirements
- R1: After a synchronous reset, both lane enables, the token output and the readout clock enable are low.
- R2: The accepted token is `start_ro` when `cfg_first` is 1. Otherwise it is `tok_prev2` when `cfg_skip` is 1, else `tok_prev`. A pulse on an unselected token input starts no transmission.
- R3: A token is accepted only after `conv_done` has closed the acquisition phase that `acq_start` opened. A token that arrives during acquisition, or before any acquisition, is ignored.
- R4: In the cycle after the token is sampled, the enabled lanes carry the header word: the stored event count, zero-extended to the word width.
- R5: In each following cycle one stored event word is sent, in write order. In the cycle after the last event word, or right after the header when the count is zero, `tok_out` is high for exactly one cycle.
- R6: Each lane enable takes the value of its `cfg_oe_*` bit when the token is accepted. It stays at that value from the header through the last event word, and drops to 0 in the same cycle that `tok_out` is high.
- R7: `ro_clk_en` is high exactly from the header cycle through the last event word, and low at all other times.
- R8: After its turn the chip ignores further tokens until a new `acq_start`.
- R9: The store holds at most DEPTH events. Writes beyond that are dropped, and the header then reports DEPTH.
- R10: `acq_start` clears the stored event count, including a repeat pulse while acquisition is already in progress.
- R11: A lane whose enable is low outputs an all-zero word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Readout clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_first | input | 1 | Chip is head of chain; token comes from start strobe |
| cfg_skip | input | 1 | Take token from chip two positions back |
| cfg_oe_a | input | 1 | Connect lane A to the bus |
| cfg_oe_b | input | 1 | Connect lane B to the bus |
| acq_start | input | 1 | Pulse: new acquisition cycle, clears store |
| conv_done | input | 1 | Pulse: conversion finished, readout armed |
| ev_wr | input | 1 | Store one event word |
| ev_data | input | WORD_W | Event word to store |
| start_ro | input | 1 | External start-readout strobe |
| tok_prev | input | 1 | Token from adjacent upstream chip |
| tok_prev2 | input | 1 | Token from chip two positions upstream |
| tok_out | output | 1 | One-cycle token to next chip |
| oe_a | output | 1 | Lane A output enable |
| oe_b | output | 1 | Lane B output enable |
| dout_a | output | WORD_W | Lane A data |
| dout_b | output | WORD_W | Lane B data |
| ro_clk_en | output | 1 | Readout clock enable, high only while transmitting |

## Verification
Turns are run with event counts of zero, one, mid-range, exactly DEPTH and above DEPTH. These counts separate the header-only path, a fencepost error at the last word, and correct saturation of the store. Token pulses are placed on the selected input, on unselected inputs, during acquisition and after the chip's own turn, which shows whether the select logic and the arming conditions gate the token correctly. Lane configurations are random, so each lane is observed both driving and held at zero, which shows that each lane's enable is independent of the other.

// File: rtl/chain_readout_pkg.sv
package chain_readout_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ACQ   = 2'd1,
    ST_READY = 2'd2,
    ST_SEND  = 2'd3
  } ro_state_t;
endpackage

// File: rtl/ro_event_store.sv
module ro_event_store #(
  parameter int WORD_W = 16,
  parameter int DEPTH  = 16,
  localparam int AW    = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              wr_en,
  input  logic [AW-1:0]     waddr,
  input  logic [WORD_W-1:0] wdata,
  input  logic              rd_en,
  input  logic [AW-1:0]     raddr,
  output logic [WORD_W-1:0] rdata
);
  logic [WORD_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) mem[waddr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (rd_en) rdata <= mem[raddr];
  end
endmodule

// File: rtl/ro_token_sel.sv
module ro_token_sel (
  input  logic cfg_first,
  input  logic cfg_skip,
  input  logic start_ro,
  input  logic tok_prev,
  input  logic tok_prev2,
  output logic tok_in
);
  always_comb begin
    if (cfg_first)     tok_in = start_ro;
    else if (cfg_skip) tok_in = tok_prev2;
    else               tok_in = tok_prev;
  end
endmodule

// File: rtl/ro_lane_drive.sv
module ro_lane_drive #(
  parameter int WORD_W = 16,
  parameter int NLANES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic              clear,
  input  logic [NLANES-1:0] lane_cfg,
  input  logic [WORD_W-1:0] word,
  output logic [NLANES-1:0] oe,
  output logic [WORD_W-1:0] dout [NLANES]
);
  for (genvar g = 0; g < NLANES; g++) begin : g_lane
    always_ff @(posedge clk) begin
      if (rst)        oe[g] <= 1'b0;
      else if (load)  oe[g] <= lane_cfg[g];
      else if (clear) oe[g] <= 1'b0;
    end
    assign dout[g] = oe[g] ? word : '0;
  end
endmodule

// File: rtl/chain_readout_ctrl.sv
module chain_readout_ctrl
  import chain_readout_pkg::*;
#(
  parameter int WORD_W = 16,
  parameter int DEPTH  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_first,
  input  logic              cfg_skip,
  input  logic              cfg_oe_a,
  input  logic              cfg_oe_b,
  input  logic              acq_start,
  input  logic              conv_done,
  input  logic              ev_wr,
  input  logic [WORD_W-1:0] ev_data,
  input  logic              start_ro,
  input  logic              tok_prev,
  input  logic              tok_prev2,
  output logic              tok_out,
  output logic              oe_a,
  output logic              oe_b,
  output logic [WORD_W-1:0] dout_a,
  output logic [WORD_W-1:0] dout_b,
  output logic              ro_clk_en
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [CW-1:0] FULL = CW'(DEPTH);
  localparam logic [CW-1:0] ONE  = CW'(1);

  ro_state_t         state_q;
  logic [CW-1:0]     cnt_q, ptr_q;
  logic              hdr_sel_q, tok_out_q, clk_en_q;
  logic              tok_in, wr_ok, rd_en, load, clear;
  logic [WORD_W-1:0] rdata, word;
  logic [1:0]        lane_oe;
  logic [WORD_W-1:0] lane_dout [2];

  ro_token_sel u_tsel (
    .cfg_first (cfg_first),
    .cfg_skip  (cfg_skip),
    .start_ro  (start_ro),
    .tok_prev  (tok_prev),
    .tok_prev2 (tok_prev2),
    .tok_in    (tok_in)
  );

  assign wr_ok = (state_q == ST_ACQ) && ev_wr && !acq_start && (cnt_q < FULL);
  assign rd_en = (state_q == ST_SEND) && (ptr_q < cnt_q);
  assign load  = (state_q == ST_READY) && !acq_start && tok_in;
  assign clear = (state_q == ST_SEND) && !rd_en;

  ro_event_store #(.WORD_W(WORD_W), .DEPTH(DEPTH)) u_store (
    .clk   (clk),
    .wr_en (wr_ok),
    .waddr (cnt_q[AW-1:0]),
    .wdata (ev_data),
    .rd_en (rd_en),
    .raddr (ptr_q[AW-1:0]),
    .rdata (rdata)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q   <= ST_IDLE;
      cnt_q     <= '0;
      ptr_q     <= '0;
      hdr_sel_q <= 1'b0;
      tok_out_q <= 1'b0;
      clk_en_q  <= 1'b0;
    end else begin
      tok_out_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (acq_start) begin
            state_q <= ST_ACQ;
            cnt_q   <= '0;
          end
        end
        ST_ACQ: begin
          if (acq_start)  cnt_q <= '0;
          else if (wr_ok) cnt_q <= cnt_q + ONE;
          if (conv_done && !acq_start) state_q <= ST_READY;
        end
        ST_READY: begin
          if (acq_start) begin
            state_q <= ST_ACQ;
            cnt_q   <= '0;
          end else if (tok_in) begin
            state_q   <= ST_SEND;
            ptr_q     <= '0;
            hdr_sel_q <= 1'b1;
            clk_en_q  <= 1'b1;
          end
        end
        ST_SEND: begin
          hdr_sel_q <= 1'b0;
          if (rd_en) begin
            ptr_q <= ptr_q + ONE;
          end else begin
            state_q   <= ST_IDLE;
            tok_out_q <= 1'b1;
            clk_en_q  <= 1'b0;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign word = hdr_sel_q ? {{(WORD_W-CW){1'b0}}, cnt_q} : rdata;

  ro_lane_drive #(.WORD_W(WORD_W), .NLANES(2)) u_lanes (
    .clk      (clk),
    .rst      (rst),
    .load     (load),
    .clear    (clear),
    .lane_cfg ({cfg_oe_b, cfg_oe_a}),
    .word     (word),
    .oe       (lane_oe),
    .dout     (lane_dout)
  );

  assign oe_a      = lane_oe[0];
  assign oe_b      = lane_oe[1];
  assign dout_a    = lane_dout[0];
  assign dout_b    = lane_dout[1];
  assign tok_out   = tok_out_q;
  assign ro_clk_en = clk_en_q;
endmodule

// File: rtl/chain_readout_chk.sv
module chain_readout_chk #(
  parameter int WORD_W = 16,
  parameter int DEPTH  = 16,
  localparam int CW    = $clog2(DEPTH + 1)
) (
  input logic              clk,
  input logic              rst,
  input logic              tok_out,
  input logic              oe_a,
  input logic              oe_b,
  input logic [WORD_W-1:0] dout_a,
  input logic [WORD_W-1:0] dout_b,
  input logic              ro_clk_en,
  input logic [CW-1:0]     cnt_q
);
  p_tok_pulse_r5: assert property (@(posedge clk) disable iff (rst)
    tok_out |=> !tok_out);

  p_tok_after_turn_r5: assert property (@(posedge clk) disable iff (rst)
    tok_out |-> (!ro_clk_en && $past(ro_clk_en)));

  p_oe_in_turn_r6: assert property (@(posedge clk) disable iff (rst)
    (oe_a || oe_b) |-> ro_clk_en);

  p_lane_a_quiet_r11: assert property (@(posedge clk) disable iff (rst)
    !oe_a |-> (dout_a == '0));

  p_lane_b_quiet_r11: assert property (@(posedge clk) disable iff (rst)
    !oe_b |-> (dout_b == '0));

  p_cnt_bound_r9: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= CW'(DEPTH));
endmodule

bind chain_readout_ctrl chain_readout_chk #(.WORD_W(WORD_W), .DEPTH(DEPTH)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .tok_out   (tok_out),
  .oe_a      (oe_a),
  .oe_b      (oe_b),
  .dout_a    (dout_a),
  .dout_b    (dout_b),
  .ro_clk_en (ro_clk_en),
  .cnt_q     (cnt_q)
);

// File: tb/chain_readout_ctrl_tb.sv
`timescale 1ns/1ps
module chain_readout_ctrl_tb;
  localparam int WORD_W = 16;
  localparam int DEPTH  = 8;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst, cfg_first, cfg_skip, cfg_oe_a, cfg_oe_b;
  logic acq_start, conv_done, ev_wr, start_ro, tok_prev, tok_prev2;
  logic [WORD_W-1:0] ev_data;
  logic tok_out, oe_a, oe_b, ro_clk_en;
  logic [WORD_W-1:0] dout_a, dout_b;

  int n_chk = 0;
  int n_bad = 0;
  logic [WORD_W-1:0] store [DEPTH+8];

  chain_readout_ctrl #(.WORD_W(WORD_W), .DEPTH(DEPTH)) u_dut (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  function automatic int exp_cnt(input int n);
    return (n > DEPTH) ? DEPTH : n;
  endfunction

  function automatic logic [WORD_W-1:0] lane(input logic en, input logic [WORD_W-1:0] w);
    return en ? w : '0;
  endfunction

  task automatic begin_acq();
    acq_start = 1'b1; tick(); acq_start = 1'b0;
  endtask

  task automatic write_events(input int n);
    for (int i = 0; i < n; i++) begin
      ev_wr = 1'b1;
      ev_data = WORD_W'($urandom);
      if (i < DEPTH + 8) store[i] = ev_data;
      tick();
    end
    ev_wr = 1'b0;
  endtask

  task automatic finish_conv();
    conv_done = 1'b1; tick(); conv_done = 1'b0;
  endtask

  task automatic pulse(input int which);
    case (which)
      0: start_ro = 1'b1;
      1: tok_prev = 1'b1;
      default: tok_prev2 = 1'b1;
    endcase
    tick();
    start_ro = 1'b0; tok_prev = 1'b0; tok_prev2 = 1'b0;
  endtask

  function automatic int sel_src();
    return cfg_first ? 0 : (cfg_skip ? 2 : 1);
  endfunction

  task automatic read_turn(input int n);
    int e = exp_cnt(n);
    logic a = cfg_oe_a, b = cfg_oe_b;
    chk("R7 clk_en at header", 32'(ro_clk_en), 1);
    chk("R6 oe_a at header", 32'(oe_a), 32'(a));
    chk("R6 oe_b at header", 32'(oe_b), 32'(b));
    chk("R4 header lane a", 32'(dout_a), 32'(lane(a, WORD_W'(e))));
    chk("R4 header lane b", 32'(dout_b), 32'(lane(b, WORD_W'(e))));
    chk("R5 no token during header", 32'(tok_out), 0);
    for (int i = 0; i < e; i++) begin
      tick();
      chk("R5 event word lane a", 32'(dout_a), 32'(lane(a, store[i])));
      chk("R11 event word lane b", 32'(dout_b), 32'(lane(b, store[i])));
      chk("R7 clk_en during data", 32'(ro_clk_en), 1);
    end
    tick();
    chk("R5 token after last word", 32'(tok_out), 1);
    chk("R6 oe_a dropped", 32'(oe_a), 0);
    chk("R6 oe_b dropped", 32'(oe_b), 0);
    chk("R7 clk_en dropped", 32'(ro_clk_en), 0);
    tick();
    chk("R5 token one cycle wide", 32'(tok_out), 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    rst = 1'b1; cfg_first = 1'b1; cfg_skip = 1'b0; cfg_oe_a = 1'b1; cfg_oe_b = 1'b1;
    acq_start = 1'b0; conv_done = 1'b0; ev_wr = 1'b0; ev_data = '0;
    start_ro = 1'b0; tok_prev = 1'b0; tok_prev2 = 1'b0;
    repeat (3) tick();
    chk("R1 oe_a reset", 32'(oe_a), 0);
    chk("R1 oe_b reset", 32'(oe_b), 0);
    chk("R1 tok_out reset", 32'(tok_out), 0);
    chk("R1 clk_en reset", 32'(ro_clk_en), 0);
    rst = 1'b0;
    tick();

    // R3: token before any acquisition
    pulse(0); tick();
    chk("R3 token in idle ignored", 32'(ro_clk_en), 0);

    // R2: head of chain, neighbour tokens ignored
    begin_acq(); write_events(3); finish_conv();
    pulse(1); pulse(2); tick();
    chk("R2 unselected token ignored", 32'(ro_clk_en), 0);
    chk("R2 unselected no oe", 32'(oe_a), 0);
    pulse(0); read_turn(3);

    // R8: second token after turn
    pulse(0); tick();
    chk("R8 token after turn ignored", 32'(ro_clk_en), 0);
    chk("R8 no token relay", 32'(tok_out), 0);

    // R3: token during acquisition, then zero events
    begin_acq(); pulse(0); tick();
    chk("R3 token in acquisition ignored", 32'(ro_clk_en), 0);
    finish_conv(); pulse(0); read_turn(0);

    // R2: skip mode, adjacent token ignored
    cfg_first = 1'b0; cfg_skip = 1'b1; cfg_oe_a = 1'b0; cfg_oe_b = 1'b1;
    begin_acq(); write_events(2); finish_conv();
    pulse(1); tick();
    chk("R2 adjacent token ignored in skip", 32'(ro_clk_en), 0);
    pulse(2); read_turn(2);

    // R9: saturation
    cfg_skip = 1'b0; cfg_oe_a = 1'b1; cfg_oe_b = 1'b0;
    begin_acq(); write_events(DEPTH + 3); finish_conv();
    pulse(1); read_turn(DEPTH + 3);

    // R10: repeated acq_start clears count
    begin_acq(); write_events(5); begin_acq(); write_events(2); finish_conv();
    pulse(1); read_turn(2);

    // Random turns
    for (int t = 0; t < 40; t++) begin
      int n = int'($urandom_range(0, DEPTH + 3));
      cfg_first = 1'($urandom); cfg_skip = 1'($urandom);
      cfg_oe_a = 1'($urandom); cfg_oe_b = 1'($urandom);
      begin_acq(); write_events(n); finish_conv();
      repeat (int'($urandom_range(0, 3))) tick();
      pulse(sel_src()); read_turn(n);
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule